// File: doc/BRIEF.md
# Serial Port Register Interface with Delayed Interrupts

This block is the processor-side register front end of a minimal byte-oriented serial port. A host reaches eight byte-wide registers, selected by a 3-bit offset, through a single-cycle synchronous access port. Read data comes back registered, one clock after the access. Behind the registers sit two byte streams. The receive stream is a byte source that shows a valid flag and is popped by a strobe. The transmit stream is a byte sink that takes a push strobe.

The block keeps a pending flag for each of two interrupt sources: received data waiting, and transmitter ready for more. It reports the more urgent of the two in an identification register and drives one level interrupt line that is the OR of both flags. No interrupt is posted at the moment its cause appears. Each source owns a down-counter that holds the interrupt back for `HOLDOFF` clock cycles. The one exception is re-enabling the transmit interrupt: that posts at once when the last transmit interrupt is already older than the hold-off.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, the enable byte (offset 1), the line control byte (offset 3) and the modem control byte (offset 4) read 0x00, the identification byte (offset 2) reads 0x01, and `irq` is low.
- R2: While bit 7 of the line control byte is set, accesses to offsets 0 and 1 reach a dummy divisor latch. Such reads return 0x00 and pop nothing, and such writes push nothing and leave the enable byte unchanged.
- R3: A read of offset 0 with bit 7 of the line control byte clear returns `rx_data` and pulses `rx_pop` in the access cycle when `rx_avail` is high. When `rx_avail` is low it returns 0x00 and does not pulse `rx_pop`.
- R4: A data read clears the receive pending flag. If enable bit 0 is set, it restarts the receive hold-off, and the flag is set `HOLDOFF` cycles after the read only if `rx_avail` is still high at that time.
- R5: A write of offset 0 with bit 7 of the line control byte clear presents the byte on `tx_data` with a `tx_push` pulse and clears the transmit pending flag. If enable bit 1 is set, it starts the transmit hold-off, so the flag sets `HOLDOFF` cycles after the write.
- R6: A read of offset 2 returns 0x04 while receive is pending, whatever the transmit state. Otherwise it returns 0x02 while transmit is pending and clears that flag. With neither pending it returns 0x01.
- R7: A write of offset 1 with bit 1 set posts the transmit interrupt in the same cycle when more than `HOLDOFF` cycles have passed since the last transmit interrupt, counting reset as long ago. Otherwise it starts the transmit hold-off.
- R8: A write of offset 1 with bit 1 clear cancels the transmit hold-off and clears the transmit pending flag. A write with bit 0 clear, or with bit 0 set while `rx_avail` is low, does the same for receive. A write with bit 0 set while `rx_avail` is high starts the receive hold-off.
- R9: `irq` is high exactly when either pending flag is set. A hold-off that expires sets its flag only if that source's enable bit is still set.
- R10: Offset 5 reads 0x60 with bit 0 set while `rx_avail` is high, so it reads 0x61 with data waiting and 0x60 without.
- R11: Offsets 6 and 7 read 0x00 and writes to offset 7 are ignored. Writing exactly 0x1A to offset 4 makes it read 0x9A, and any other write to offset 4 is ignored.
- R12: With enable bit 0 set, a rising edge of `rx_avail` starts the receive hold-off. Arming a source that is already counting restarts its count at `HOLDOFF`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ofs | input | 3 | Register offset |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid the cycle after a read |
| rx_avail | input | 1 | Receive source holds a byte |
| rx_data | input | 8 | Byte at the head of the receive source |
| rx_pop | output | 1 | Consume the head byte (combinational) |
| tx_data | output | 8 | Byte for the transmit sink |
| tx_push | output | 1 | Transmit byte valid (combinational) |
| irq | output | 1 | Interrupt line |

## Verification
The transmit path is driven three ways. An enable write long after any transmit interrupt separates immediate posting from delayed posting. An enable write made right after an interrupt must wait the full hold-off, and a data write both clears the flag and re-arms it. The receive path runs with two queued bytes and then with the queue drained, which shows whether a re-armed hold-off checks that data is still present when it expires, and with a byte arriving while receive is enabled, which exercises edge arming. With both sources pending, repeated identification reads must keep reporting receive and must not consume the transmit flag. Divisor-latch mode, the modem-control pattern and the dead registers are then probed to show that those accesses touch neither the streams nor the stored bytes.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [2:0] {
        OFS_DATA      = 3'd0,
        OFS_IEN       = 3'd1,
        OFS_ID        = 3'd2,
        OFS_LINECTL   = 3'd3,
        OFS_MODEMCTL  = 3'd4,
        OFS_LINESTAT  = 3'd5,
        OFS_MODEMSTAT = 3'd6,
        OFS_SCRATCH   = 3'd7
    } reg_ofs_e;

    localparam int NSRC       = 2;
    localparam int SRC_RX     = 0;
    localparam int SRC_TX     = 1;
    localparam int LATCH_BIT  = 7;

    localparam logic [7:0] ID_RX    = 8'h04;
    localparam logic [7:0] ID_TX    = 8'h02;
    localparam logic [7:0] ID_NONE  = 8'h01;
    localparam logic [7:0] MC_MATCH = 8'h1A;
    localparam logic [7:0] MC_VALUE = 8'h9A;

    // decoded register events for one access cycle
    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic wr_ien;
        logic rd_id;
    } reg_evt_t;

    function automatic logic [7:0] id_code(input logic [NSRC-1:0] pend);
        if (pend[SRC_RX])      return ID_RX;
        else if (pend[SRC_TX]) return ID_TX;
        else                   return ID_NONE;
    endfunction

    function automatic logic [7:0] line_status(input logic ready);
        return {1'b0, 1'b1, 1'b1, 4'b0000, ready};
    endfunction

endpackage

// File: rtl/sreg_holdoff.sv
module sreg_holdoff #(
    parameter int HOLDOFF = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic cancel,
    output logic fire
);
    localparam int CW = $clog2(HOLDOFF + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLDOFF);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (arm)          cnt <= LOAD;
        else if (cancel)       cnt <= '0;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign fire = (cnt == CW'(1)) && !arm && !cancel;

    // R12
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD);

    // R12
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (cnt == LOAD));
endmodule

// File: rtl/sreg_irq.sv
module sreg_irq
    import sreg_pkg::*;
#(
    parameter int HOLDOFF = 28
) (
    input  logic            clk,
    input  logic            rst,
    input  reg_evt_t        ev,
    input  logic [1:0]      ien_new,
    input  logic [1:0]      ien_cur,
    input  logic            rx_avail,
    output logic [NSRC-1:0] pend,
    output logic            irq
);
    localparam int AW = $clog2(HOLDOFF + 2);
    localparam logic [AW-1:0] AGE_MAX = AW'(HOLDOFF + 1);

    logic            avail_q;
    logic            avail_rise;
    logic [AW-1:0]   tx_age;
    logic            tx_aged;
    logic            tx_now;
    logic [NSRC-1:0] arm, cancel, fire, fire_ok;
    logic            tx_set;
    logic [NSRC-1:0] pend_n;

    assign avail_rise = rx_avail && !avail_q;
    assign tx_aged    = tx_age > AW'(HOLDOFF);
    assign tx_now     = ev.wr_ien && ien_new[1] && tx_aged;

    always_comb begin
        arm[SRC_RX]    = (ev.rd_data && ien_cur[0])
                       || (ev.wr_ien && ien_new[0] && rx_avail)
                       || (avail_rise && ien_cur[0] && !ev.wr_ien);
        cancel[SRC_RX] = ev.wr_ien && !(ien_new[0] && rx_avail);
        arm[SRC_TX]    = (ev.wr_data && ien_cur[1])
                       || (ev.wr_ien && ien_new[1] && !tx_aged);
        cancel[SRC_TX] = ev.wr_ien && (!ien_new[1] || tx_aged);
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        sreg_holdoff #(.HOLDOFF(HOLDOFF)) u_hold (
            .clk    (clk),
            .rst    (rst),
            .arm    (arm[s]),
            .cancel (cancel[s]),
            .fire   (fire[s])
        );
    end

    assign fire_ok[SRC_RX] = fire[SRC_RX] && ien_cur[0] && rx_avail;
    assign fire_ok[SRC_TX] = fire[SRC_TX] && ien_cur[1];
    assign tx_set          = fire_ok[SRC_TX] || tx_now;

    always_comb begin
        pend_n = pend;
        if (fire_ok[SRC_RX]) pend_n[SRC_RX] = 1'b1;
        if (ev.rd_data || cancel[SRC_RX]) pend_n[SRC_RX] = 1'b0;
        if (tx_set) pend_n[SRC_TX] = 1'b1;
        if (ev.wr_data || (ev.wr_ien && !ien_new[1])
            || (ev.rd_id && !pend[SRC_RX]))
            pend_n[SRC_TX] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            avail_q <= 1'b0;
            tx_age  <= AGE_MAX;
        end else begin
            pend    <= pend_n;
            avail_q <= rx_avail;
            if (tx_set)                tx_age <= '0;
            else if (tx_age < AGE_MAX) tx_age <= tx_age + 1'b1;
        end
    end

    assign irq = |pend;

    // R7
    tx_now_chk: assert property (@(posedge clk) disable iff (rst)
        tx_now |=> pend[SRC_TX]);

    // R8
    rx_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.wr_ien && !ien_new[0]) |=> !pend[SRC_RX]);

    // R8
    tx_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.wr_ien && !ien_new[1]) |=> !pend[SRC_TX]);

    // R5
    tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ev.wr_data |=> !pend[SRC_TX]);
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import sreg_pkg::*;
#(
    parameter int HOLDOFF = 28
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_en,
    input  logic       acc_wr,
    input  logic [2:0] acc_ofs,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata,
    input  logic       rx_avail,
    input  logic [7:0] rx_data,
    output logic       rx_pop,
    output logic [7:0] tx_data,
    output logic       tx_push,
    output logic       irq
);
    logic [7:0]      ien_q, lcr_q, mcr_q, rdata_q, rd_val;
    logic            latch_sel, is_rd, is_wr;
    reg_ofs_e        ofs;
    reg_evt_t        ev;
    logic [NSRC-1:0] pend;

    assign ofs       = reg_ofs_e'(acc_ofs);
    assign latch_sel = lcr_q[LATCH_BIT];
    assign is_rd     = acc_en && !acc_wr;
    assign is_wr     = acc_en && acc_wr;

    always_comb begin
        ev.rd_data = is_rd && (ofs == OFS_DATA) && !latch_sel;
        ev.wr_data = is_wr && (ofs == OFS_DATA) && !latch_sel;
        ev.wr_ien  = is_wr && (ofs == OFS_IEN)  && !latch_sel;
        ev.rd_id   = is_rd && (ofs == OFS_ID);
    end

    assign rx_pop  = ev.rd_data && rx_avail;
    assign tx_push = ev.wr_data;
    assign tx_data = acc_wdata;

    always_comb begin
        rd_val = 8'h00;
        unique case (ofs)
            OFS_DATA:      rd_val = (!latch_sel && rx_avail) ? rx_data : 8'h00;
            OFS_IEN:       rd_val = latch_sel ? 8'h00 : ien_q;
            OFS_ID:        rd_val = id_code(pend);
            OFS_LINECTL:   rd_val = lcr_q;
            OFS_MODEMCTL:  rd_val = mcr_q;
            OFS_LINESTAT:  rd_val = line_status(rx_avail);
            OFS_MODEMSTAT: rd_val = 8'h00;
            OFS_SCRATCH:   rd_val = 8'h00;
            default:       rd_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            lcr_q   <= '0;
            mcr_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (is_rd) rdata_q <= rd_val;
            if (ev.wr_ien) ien_q <= acc_wdata;
            if (is_wr && ofs == OFS_LINECTL) lcr_q <= acc_wdata;
            if (is_wr && ofs == OFS_MODEMCTL && acc_wdata == MC_MATCH)
                mcr_q <= MC_VALUE;
        end
    end

    assign acc_rdata = rdata_q;

    sreg_irq #(.HOLDOFF(HOLDOFF)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .ien_new  (acc_wdata[1:0]),
        .ien_cur  (ien_q[1:0]),
        .rx_avail (rx_avail),
        .pend     (pend),
        .irq      (irq)
    );

    // R6
    id_rx_first_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rd_id && pend[SRC_RX]) |=> (acc_rdata == ID_RX));

    // R6
    id_keeps_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rd_id && pend[SRC_RX] && pend[SRC_TX] && !ev.wr_ien) |=> pend[SRC_TX]);

    // R2
    latch_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (is_rd && latch_sel && acc_ofs <= 3'd1) |=> (acc_rdata == 8'h00));

    // R10
    line_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (is_rd && ofs == OFS_LINESTAT) |=> (acc_rdata[6:5] == 2'b11));

    // R3
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (rx_avail && !latch_sel));
endmodule

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
    localparam int HOLD = 28;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_en, acc_wr;
    logic [2:0] acc_ofs;
    logic [7:0] acc_wdata, acc_rdata;
    logic       rx_avail, rx_pop, tx_push, irq;
    logic [7:0] rx_data, tx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] rxq [8];
    int         q_head = 0;
    int         q_tail = 0;

    logic       pop_seen, push_seen;
    logic [7:0] push_byte;
    logic [7:0] rd;

    always #4 clk = ~clk;

    assign rx_avail = (q_head != q_tail);
    assign rx_data  = rxq[q_head % 8];

    always @(posedge clk) if (rx_pop) q_head <= q_head + 1;

    serial_reg_port #(.HOLDOFF(HOLD)) u_dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_ofs(acc_ofs), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .rx_avail(rx_avail), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_data(tx_data), .tx_push(tx_push), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [2:0] ofs, input logic [7:0] wd);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_ofs = ofs; acc_wdata = wd;
        #1;
        pop_seen = rx_pop; push_seen = tx_push; push_byte = tx_data;
        @(posedge clk); #1;
        rd = acc_rdata;
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic feed(input logic [7:0] b);
        @(negedge clk);
        rxq[q_tail % 8] = b;
        q_tail = q_tail + 1;
    endtask

    task automatic t_reset();
        bus(0, 3'd1, 0); check("R1 enable byte", rd, 8'h00);
        bus(0, 3'd3, 0); check("R1 line control", rd, 8'h00);
        bus(0, 3'd4, 0); check("R1 modem control", rd, 8'h00);
        bus(0, 3'd2, 0); check("R1 id", rd, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        bus(0, 3'd5, 0); check("R10 status empty", rd, 8'h60);
    endtask

    task automatic t_tx_enable();
        bus(1, 3'd0, 8'h5A);
        check("R5 push strobe", {7'd0, push_seen}, 8'h01);
        check("R5 push byte", push_byte, 8'h5A);
        bus(1, 3'd1, 8'h02);
        check("R7 immediate irq", {7'd0, irq}, 8'h01);
        bus(0, 3'd2, 0); check("R6 id tx", rd, 8'h02);
        check("R9 irq drops", {7'd0, irq}, 8'h00);
        bus(0, 3'd2, 0); check("R6 id none", rd, 8'h01);
        bus(1, 3'd1, 8'h02);
        check("R7 delayed start", {7'd0, irq}, 8'h00);
        cycles(HOLD - 1);
        check("R7 before hold-off", {7'd0, irq}, 8'h00);
        cycles(1);
        check("R7 at hold-off", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_tx_write();
        bus(1, 3'd0, 8'h33);
        check("R5 push byte 2", push_byte, 8'h33);
        check("R5 pending cleared", {7'd0, irq}, 8'h00);
        cycles(HOLD - 1);
        check("R5 before hold-off", {7'd0, irq}, 8'h00);
        cycles(1);
        check("R5 at hold-off", {7'd0, irq}, 8'h01);
        bus(0, 3'd2, 0); check("R6 id tx again", rd, 8'h02);
    endtask

    task automatic t_cancel();
        bus(1, 3'd0, 8'h44);
        bus(1, 3'd1, 8'h00);
        cycles(HOLD + 2);
        check("R8 cancelled tx", {7'd0, irq}, 8'h00);
        bus(0, 3'd2, 0); check("R8 id none", rd, 8'h01);
    endtask

    task automatic t_rx();
        feed(8'h11); feed(8'h22);
        cycles(2);
        bus(0, 3'd5, 0); check("R10 status ready", rd, 8'h61);
        bus(1, 3'd1, 8'h01);
        cycles(HOLD - 1);
        check("R8 rx armed wait", {7'd0, irq}, 8'h00);
        cycles(1);
        check("R8 rx armed fire", {7'd0, irq}, 8'h01);
        bus(0, 3'd2, 0); check("R6 id rx", rd, 8'h04);
        bus(0, 3'd0, 0);
        check("R3 first byte", rd, 8'h11);
        check("R3 pop", {7'd0, pop_seen}, 8'h01);
        check("R4 cleared", {7'd0, irq}, 8'h00);
        cycles(HOLD - 1);
        check("R4 rearm wait", {7'd0, irq}, 8'h00);
        cycles(1);
        check("R4 rearm fire", {7'd0, irq}, 8'h01);
        bus(0, 3'd0, 0); check("R3 second byte", rd, 8'h22);
        cycles(HOLD + 2);
        check("R4 no data no irq", {7'd0, irq}, 8'h00);
        bus(0, 3'd0, 0);
        check("R3 empty read", rd, 8'h00);
        check("R3 empty no pop", {7'd0, pop_seen}, 8'h00);
    endtask

    task automatic t_rx_edge();
        feed(8'h3C);
        cycles(HOLD - 1);
        check("R12 edge wait", {7'd0, irq}, 8'h00);
        cycles(2);
        check("R12 edge fire", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_priority();
        bus(1, 3'd1, 8'h03);
        bus(0, 3'd2, 0); check("R6 rx first", rd, 8'h04);
        bus(0, 3'd2, 0); check("R6 rx still first", rd, 8'h04);
        bus(0, 3'd0, 0); check("R3 third byte", rd, 8'h3C);
        bus(0, 3'd2, 0); check("R6 tx kept", rd, 8'h02);
        bus(0, 3'd2, 0); check("R6 tx consumed", rd, 8'h01);
        check("R9 irq idle", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_latch();
        feed(8'h99);
        bus(1, 3'd3, 8'h80);
        bus(0, 3'd3, 0); check("R2 line control", rd, 8'h80);
        bus(0, 3'd0, 0);
        check("R2 latch read", rd, 8'h00);
        check("R2 latch no pop", {7'd0, pop_seen}, 8'h00);
        bus(1, 3'd0, 8'h77);
        check("R2 latch no push", {7'd0, push_seen}, 8'h00);
        bus(1, 3'd1, 8'h00);
        bus(0, 3'd1, 0); check("R2 latch high", rd, 8'h00);
        bus(1, 3'd3, 8'h03);
        bus(0, 3'd1, 0); check("R2 enable kept", rd, 8'h03);
        bus(0, 3'd0, 0); check("R3 drain", rd, 8'h99);
        bus(1, 3'd1, 8'h00);
    endtask

    task automatic t_misc();
        bus(1, 3'd4, 8'h55);
        bus(0, 3'd4, 0); check("R11 modem ignored", rd, 8'h00);
        bus(1, 3'd4, 8'h1A);
        bus(0, 3'd4, 0); check("R11 modem pattern", rd, 8'h9A);
        bus(1, 3'd4, 8'h00);
        bus(0, 3'd4, 0); check("R11 modem kept", rd, 8'h9A);
        bus(0, 3'd6, 0); check("R11 modem status", rd, 8'h00);
        bus(1, 3'd7, 8'h44);
        bus(0, 3'd7, 0); check("R11 scratch", rd, 8'h00);
        check("R9 final irq", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc_en = 1'b0; acc_wr = 1'b0; acc_ofs = '0; acc_wdata = '0;
        pop_seen = 1'b0; push_seen = 1'b0; push_byte = '0; rd = '0;
        for (int i = 0; i < 8; i++) rxq[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_tx_enable();
        t_tx_write();
        t_cancel();
        t_rx();
        t_rx_edge();
        t_priority();
        t_latch();
        t_misc();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule